// File: doc/BRIEF.md
# Threshold-Terminated Accumulator

This block sums a stream of unsigned samples into a running total and stops on its own once that total rises above a fixed limit. The number of cycles a run takes therefore depends on the data, not on a count chosen in advance. The control is an explicit three-state machine (idle, accumulating, finished), so the repetition happens across clock cycles rather than through a loop with timing inside it.

A client pulses `start_i` while the block is idle. This clears the total, and from the next cycle on one sample per clock is taken from `din_i`. After each addition the new total is compared against the `THRESH` parameter. When the total is strictly larger, the block raises `done_o` for a single cycle and then returns to idle. The final total stays on `sum_o` until the next accepted start. Addition wraps at the data width, and the comparison sees the wrapped value.

Top module: `thresh_accum`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the block enters idle, `sum_o` becomes 0 and `done_o` becomes 0.
- R2: A high `start_i` at an edge while idle sets `sum_o` to 0 and enters the accumulating state, with `done_o` low.
- R3: At each edge in the accumulating state, `din_i` is added to `sum_o` exactly once, modulo 2^DATA_W.
- R4: The run ends when the updated total is strictly greater than `THRESH` (default 42). A total equal to `THRESH` does not end the run. `done_o` is high in the cycle that follows the edge of the terminating addition.
- R5: `done_o` stays high for exactly one cycle, and the block is idle after it.
- R6: From the terminating addition until the next accepted start, `sum_o` holds its value whatever `din_i` carries.
- R7: `start_i` has no effect while accumulating or while `done_o` is high.
- R8: The comparison uses the wrapped total. A run whose total overflows to a value at or below `THRESH` keeps accumulating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begins a run when the block is idle |
| din_i | input | DATA_W | Unsigned sample added once per accumulating cycle |
| sum_o | output | DATA_W | Running or final total |
| done_o | output | 1 | One-cycle flag marking the end of a run |

## Verification
The bench builds the block with the default values, DATA_W = 8 and THRESH = 42. With these values a single sample can overflow the total, so runs whose total wraps back below the limit and keeps going can be reached with a handful of samples. The limit is also low enough to test both the total that lands exactly on it and the one that passes it by one. Long runs of zero samples show that termination depends on the data and not on a cycle count.

// File: rtl/tacc_pkg.sv
package tacc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ACCUM = 2'd1,
      ST_DONE  = 2'd2
   } tacc_state_e;

endpackage

// File: rtl/tacc_addcmp.sv
// Combinational step: wrapped addition and strict compare against the limit.
module tacc_addcmp #(
   parameter int DATA_W = 8,
   parameter int THRESH = 42
) (
   input  logic [DATA_W-1:0] sum_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] next_o,
   output logic              over_o
);
   localparam logic [DATA_W-1:0] LIMIT = DATA_W'(THRESH);

   always_comb begin
      next_o = sum_i + din_i;
      over_o = (next_o > LIMIT);
   end
endmodule

// File: rtl/tacc_ctrl.sv
// Three-state sequencer that replaces the data-dependent loop.
module tacc_ctrl
   import tacc_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_i,
   input  logic        start_i,
   input  logic        over_i,
   output tacc_state_e state_o,
   output logic        clr_o,
   output logic        load_o,
   output logic        done_o
);
   tacc_state_e st_q, st_d;

   always_comb begin
      st_d   = st_q;
      clr_o  = 1'b0;
      load_o = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               clr_o = 1'b1;
               st_d  = ST_ACCUM;
            end
         end
         ST_ACCUM: begin
            load_o = 1'b1;
            if (over_i) st_d = ST_DONE;
         end
         ST_DONE:  st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) st_q <= ST_IDLE;
      else       st_q <= st_d;
   end

   assign state_o = st_q;
   assign done_o  = (st_q == ST_DONE);
endmodule

// File: rtl/tacc_sumreg.sv
// Total register: clear, load or hold.
module tacc_sumreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              clr_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] next_i,
   output logic [DATA_W-1:0] sum_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) sum_o <= '0;
      else if (load_i)    sum_o <= next_i;
   end
endmodule

// File: rtl/thresh_accum.sv
module thresh_accum
   import tacc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int THRESH = 42
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              start_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              done_o
);
   localparam longint MAX_SUM = (longint'(1) << DATA_W) - 1;

   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
      $error("thresh_accum: DATA_W must lie in 1..32");
   end
   if (THRESH < 0 || longint'(THRESH) >= MAX_SUM) begin : g_bad_limit
      $error("thresh_accum: THRESH must be below the largest total");
   end

   tacc_state_e       state_q;
   logic              clr, load, over;
   logic [DATA_W-1:0] sum_next;

   tacc_addcmp #(.DATA_W(DATA_W), .THRESH(THRESH)) u_step (
      .sum_i (sum_o),
      .din_i (din_i),
      .next_o(sum_next),
      .over_o(over)
   );

   tacc_ctrl u_ctrl (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .start_i(start_i),
      .over_i (over),
      .state_o(state_q),
      .clr_o  (clr),
      .load_o (load),
      .done_o (done_o)
   );

   tacc_sumreg #(.DATA_W(DATA_W)) u_sum (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .clr_i (clr),
      .load_i(load),
      .next_i(sum_next),
      .sum_o (sum_o)
   );
endmodule

// File: rtl/thresh_accum_chk.sv
module thresh_accum_chk
   import tacc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int THRESH = 42
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              start_i,
   input logic [DATA_W-1:0] din_i,
   input logic [DATA_W-1:0] sum_o,
   input logic              done_o,
   input tacc_state_e       state_i
);
   localparam logic [DATA_W-1:0] LIMIT = DATA_W'(THRESH);

   AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_i == ST_IDLE && start_i) |=> (sum_o == '0 && state_i == ST_ACCUM && !done_o)); // R2

   AST_ONE_ADD: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_i == ST_ACCUM) |=> (sum_o == DATA_W'($past(sum_o) + $past(din_i)))); // R3

   AST_STOP_RULE: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_i == ST_ACCUM) |=> (done_o == (sum_o > LIMIT))); // R4

   AST_DONE_ABOVE: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> (sum_o > LIMIT)); // R4

   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> (!done_o && state_i == ST_IDLE)); // R5

   AST_HOLD_TOTAL: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_o || (state_i == ST_IDLE && !start_i)) |=> $stable(sum_o)); // R6

   AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_i == ST_DONE && start_i) |=> (state_i == ST_IDLE)); // R7
endmodule

bind thresh_accum thresh_accum_chk #(.DATA_W(DATA_W), .THRESH(THRESH)) u_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .start_i(start_i),
   .din_i  (din_i),
   .sum_o  (sum_o),
   .done_o (done_o),
   .state_i(state_q)
);

// File: tb/thresh_accum_test.sv
`timescale 1ns/1ps
module thresh_accum_test;
   localparam int W     = 8;
   localparam int LIMIT = 42;

   logic         clk = 1'b0;
   logic         rst, start;
   logic [W-1:0] din;
   logic [W-1:0] sum;
   logic         done;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;
   logic [W-1:0] sb_q[$];

   always #5 clk = ~clk;

   thresh_accum #(.DATA_W(W), .THRESH(LIMIT)) uut (
      .clk_i(clk), .rst_i(rst), .start_i(start),
      .din_i(din), .sum_o(sum), .done_o(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard whenever a run finishes.
   initial begin
      forever begin
         @(negedge clk); #1;
         if (!rst && done) begin
            if (sb_q.size() == 0) chk(1'b0, "R4 unexpected done", int'(sum), -1);
            else begin
               logic [W-1:0] e;
               e = sb_q.pop_front();
               chk(sum == e, "R3 final total", int'(sum), int'(e));
            end
         end
      end
   end

   // Driver: one run; samples beyond the terminating one are not sent.
   task automatic run(input logic [W-1:0] s[$], input bit poke_mid, input bit poke_done);
      logic [W-1:0] acc = '0;
      int n = 0;
      logic [W-1:0] held;
      for (int i = 0; i < s.size(); i++) begin
         acc = acc + s[i];
         n++;
         if (acc > W'(LIMIT)) break;
      end
      start = 1'b1; din = 8'hA5;
      @(negedge clk);
      chk(sum == 0, "R2 cleared at start", int'(sum), 0);
      chk(done == 1'b0, "R2 no done at start", int'(done), 0);
      acc = '0;
      for (int i = 0; i < n; i++) begin
         din   = s[i];
         start = (poke_mid && i == 1);   // R7: ignored mid-run
         acc   = acc + s[i];
         if (i == n - 1) sb_q.push_back(acc);
         @(negedge clk);
         if (i < n - 1) begin
            chk(done == 1'b0, "R4 no early done", int'(done), 0);
            chk(sum == acc, "R3 running total", int'(sum), int'(acc));
         end
      end
      chk(done == 1'b1, "R4 done after terminating add", int'(done), 1);
      held  = acc;
      start = poke_done;                 // R7: ignored during done
      din   = 8'hFF;
      @(negedge clk);
      chk(done == 1'b0, "R5 done lasts one cycle", int'(done), 0);
      chk(sum == held, "R6 total held", int'(sum), int'(held));
      start = 1'b0; din = 8'h33;
      @(negedge clk);
      chk(sum == held, "R7 start in done ignored / R6 hold", int'(sum), int'(held));
      chk(done == 1'b0, "R5 idle after done", int'(done), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] q[$];
      rst = 1'b1; start = 1'b0; din = 8'h77;
      repeat (2) @(negedge clk);
      chk(sum == 0, "R1 reset total", int'(sum), 0);
      chk(done == 1'b0, "R1 reset done", int'(done), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(sum == 0, "R6 idle hold", int'(sum), 0);

      q = '{8'd10, 8'd20, 8'd13};                 run(q, 1'b0, 1'b0); // R4 basic
      q = '{8'd42, 8'd1};                         run(q, 1'b0, 1'b0); // R4 equal does not stop
      q = '{8'd30, 8'd240, 8'd10, 8'd20};         run(q, 1'b0, 1'b0); // R8 wrap continues
      q = '{8'd200};                              run(q, 1'b0, 1'b1); // R4 single sample, R7
      q = '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd43}; run(q, 1'b1, 1'b0); // R7 mid-run start
      q = '{8'd40, 8'd250, 8'd60};                run(q, 1'b1, 1'b1); // R8 wrap then stop

      // R1: reset in the middle of a run
      start = 1'b1; @(negedge clk);
      start = 1'b0; din = 8'd20; @(negedge clk);
      chk(sum == 20, "R3 add before reset", int'(sum), 20);
      rst = 1'b1; @(negedge clk);
      chk(sum == 0, "R1 reset mid-run total", int'(sum), 0);
      chk(done == 1'b0, "R1 reset mid-run done", int'(done), 0);
      rst = 1'b0; din = 8'd50; @(negedge clk);
      chk(sum == 0, "R1 idle after reset", int'(sum), 0);
      q = '{8'd50}; run(q, 1'b0, 1'b0);

      @(negedge clk);
      chk(sb_q.size() == 0, "R4 every run finished", sb_q.size(), 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule